// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Controller

This block holds the status and error flags of an SPI peripheral and combines them into one interrupt request. It watches the slave-select pin, the slave-select management mode and the software select bit. When the unit is master and sees a select conflict, it switches the unit off, drops it to slave mode and locks the enable and master-select bits until software clears the fault.

It also owns the receive holding register and its not-empty flag. An arriving word that finds the buffer still full is dropped, and the overrun flag is raised. The CRC compare result raises the CRC-error flag. The transmit-empty flag follows the transmit-taken and data-write strobes. Software clears each error flag through an ordered pair of register accesses, which the bus interface reports as one-cycle strobes. If another access to the same registers falls between the two steps, the sequence starts over.

Top module: `spi_err_irq`

## Requirements
- R1: On reset (rstN low) every flag, both lock bits, periphEn, masterSel, rxData and irq are 0.
- R2: A control write (ctrlWr) with the lock clear loads periphEn from wrEnable and masterSel from wrMaster on the next clock edge.
- R3: With masterSel=1 and nssHwMode=1, nssPin=0 sets modeFault and clears periphEn and masterSel on the next edge.
- R4: With masterSel=1 and nssHwMode=0, ssiBit=0 sets modeFault and clears periphEn and masterSel on the next edge.
- R5: While modeFault is set, control writes leave periphEn and masterSel at 0. This includes the write that clears the fault, and a write in the same cycle as a fault is also ignored.
- R6: modeFault clears on a control write that follows a status read or status write. A data read between the two steps cancels the sequence.
- R7: rxValid with rxNotEmpty=0, or in the same cycle as datRd, stores rxWord in rxData and sets rxNotEmpty without an overrun. datRd alone clears rxNotEmpty.
- R8: rxValid with rxNotEmpty=1 and no datRd sets overrun and leaves rxData unchanged.
- R9: overrun clears on a status read that follows a data read. A status write between the two steps cancels the sequence.
- R10: crcCheck with crcOk=0 sets crcError. A status write with stsWrCrcErr=0 clears it, and setting wins when both happen in the same cycle.
- R11: txTaken sets txEmpty and datWr clears it. txTaken wins when both happen in the same cycle.
- R12: irq = (txEmpty & teIntEn) | (rxNotEmpty & rneIntEn) | (errIntEn & (modeFault | overrun | crcError)), with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nssPin | input | 1 | Slave-select pin level |
| nssHwMode | input | 1 | 1 = pin-managed select, 0 = software-managed |
| ssiBit | input | 1 | Software select bit |
| ctrlWr | input | 1 | Control register write strobe |
| wrEnable | input | 1 | Enable value carried by the control write |
| wrMaster | input | 1 | Master-select value carried by the control write |
| stsRd | input | 1 | Status register read strobe |
| stsWr | input | 1 | Status register write strobe |
| stsWrCrcErr | input | 1 | CRC-error bit value carried by the status write |
| datRd | input | 1 | Data register read strobe |
| datWr | input | 1 | Data register write strobe |
| txTaken | input | 1 | Shift engine took the transmit word |
| rxValid | input | 1 | Shift engine delivers a received word |
| rxWord | input | DATA_W | Received word |
| crcCheck | input | 1 | CRC compare result is valid |
| crcOk | input | 1 | Received CRC equals expected CRC |
| teIntEn | input | 1 | Transmit-empty interrupt enable |
| rneIntEn | input | 1 | Receive-not-empty interrupt enable |
| errIntEn | input | 1 | Shared error interrupt enable |
| periphEn | output | 1 | Peripheral enable bit |
| masterSel | output | 1 | Master-select bit |
| txEmpty | output | 1 | Transmit-empty flag |
| rxNotEmpty | output | 1 | Receive-not-empty flag |
| modeFault | output | 1 | Mode-fault flag |
| overrun | output | 1 | Overrun flag |
| crcError | output | 1 | CRC-error flag |
| rxData | output | DATA_W | Receive holding register |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: capturing a received word and reading the data register. The bench holds a word unread and then drives rxValid and datRd together. The new word must appear in rxData, rxNotEmpty must stay high and overrun must stay low. A second step drives rxValid alone and expects the overrun flag and the older data. A control write in the same cycle as a mode fault is checked the same way: the fault must win.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  // Strobes from the sequence control to the flag datapath.
  typedef struct packed {
    logic modfHit;  // fault condition seen this cycle
    logic clrModf;  // mode-fault clear sequence completed
    logic clrOvr;   // overrun clear sequence completed
    logic setCrc;   // CRC mismatch reported
    logic clrCrc;   // status write of 0 to the CRC-error bit
  } flagStrobes_t;
endpackage

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         nssPin,
  input  logic         nssHwMode,
  input  logic         ssiBit,
  input  logic         masterSel,
  input  logic         modfFlag,
  input  logic         ovrFlag,
  input  logic         ctrlWr,
  input  logic         stsRd,
  input  logic         stsWr,
  input  logic         stsWrCrcErr,
  input  logic         datRd,
  input  logic         crcCheck,
  input  logic         crcOk,
  output flagStrobes_t strb
);
  logic modfArm;
  logic ovrArm;
  logic selLost;
  logic stsAny;

  assign stsAny  = stsRd | stsWr;
  assign selLost = nssHwMode ? ~nssPin : ~ssiBit;

  always_comb begin
    strb         = '0;
    strb.modfHit = masterSel & selLost;
    strb.clrModf = modfFlag & modfArm & ctrlWr;
    strb.clrOvr  = ovrFlag & ovrArm & stsRd;
    strb.setCrc  = crcCheck & ~crcOk;
    strb.clrCrc  = stsWr & ~stsWrCrcErr;
  end

  // Mode-fault clear: status access arms, control write completes, data read aborts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 modfArm <= 1'b0;
    else if (!modfFlag)        modfArm <= 1'b0;
    else if (strb.clrModf)     modfArm <= 1'b0;
    else if (stsAny)           modfArm <= 1'b1;
    else if (datRd || ctrlWr)  modfArm <= 1'b0;
  end

  // Overrun clear: data read arms, status read completes, status write aborts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ovrArm <= 1'b0;
    else if (!ovrFlag)        ovrArm <= 1'b0;
    else if (strb.clrOvr)     ovrArm <= 1'b0;
    else if (datRd)           ovrArm <= 1'b1;
    else if (stsAny)          ovrArm <= 1'b0;
  end

  // R6: the fault flag only falls through a control write
  a_r6_modf_clear_by_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modfFlag) |-> $past(ctrlWr));
  // R9: the overrun flag only falls through a status read
  a_r9_ovr_clear_by_sts: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovrFlag) |-> $past(stsRd));
endmodule

// File: rtl/spi_flag_dp.sv
module spi_flag_dp
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strb,
  input  logic              ctrlWr,
  input  logic              wrEnable,
  input  logic              wrMaster,
  input  logic              datRd,
  input  logic              datWr,
  input  logic              txTaken,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              teIntEn,
  input  logic              rneIntEn,
  input  logic              errIntEn,
  output logic              periphEn,
  output logic              masterSel,
  output logic              txEmpty,
  output logic              rxNotEmpty,
  output logic              modeFault,
  output logic              overrun,
  output logic              crcError,
  output logic [DATA_W-1:0] rxData,
  output logic              irq
);
  logic ctrlLock;
  logic rxAccept;
  logic rxDrop;

  assign rxAccept = rxValid & (~rxNotEmpty | datRd);
  assign rxDrop   = rxValid & rxNotEmpty & ~datRd;

  // Enable, master-select and the write lock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periphEn  <= 1'b0;
      masterSel <= 1'b0;
      modeFault <= 1'b0;
      ctrlLock  <= 1'b0;
    end else if (strb.modfHit) begin
      periphEn  <= 1'b0;
      masterSel <= 1'b0;
      modeFault <= 1'b1;
      ctrlLock  <= 1'b1;
    end else begin
      if (strb.clrModf) begin
        modeFault <= 1'b0;
        ctrlLock  <= 1'b0;
      end
      if (ctrlWr && !ctrlLock) begin
        periphEn  <= wrEnable;
        masterSel <= wrMaster;
      end
    end
  end

  // Receive holding register, not-empty and overrun.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxNotEmpty <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (rxAccept) begin
        rxData     <= rxWord;
        rxNotEmpty <= 1'b1;
      end else if (datRd) begin
        rxNotEmpty <= 1'b0;
      end
      if (rxDrop)           overrun <= 1'b1;
      else if (strb.clrOvr) overrun <= 1'b0;
    end
  end

  // CRC error and transmit empty: set has priority.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcError <= 1'b0;
      txEmpty  <= 1'b0;
    end else begin
      if (strb.setCrc)      crcError <= 1'b1;
      else if (strb.clrCrc) crcError <= 1'b0;
      if (txTaken)          txEmpty <= 1'b1;
      else if (datWr)       txEmpty <= 1'b0;
    end
  end

  assign irq = (txEmpty & teIntEn) | (rxNotEmpty & rneIntEn) |
               (errIntEn & (modeFault | overrun | crcError));

  // R3 and R4: a new fault leaves the unit off and in slave mode
  a_r3_r4_fault_forces_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> (!periphEn && !masterSel));
  // R5: a set fault blocks both bits for the following cycle
  a_r5_locked_off: assert property (@(posedge clk) disable iff (!rstN)
    modeFault |=> (!periphEn && !masterSel));
  // R7: a word into an empty buffer marks it full
  a_r7_capture_sets_rne: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxNotEmpty) |=> rxNotEmpty);
  // R8: a dropped word leaves the held data alone
  a_r8_drop_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxNotEmpty && !datRd) |=> ($stable(rxData) && overrun));
  // R12: an enabled error flag always requests an interrupt
  a_r12_err_irq: assert property (@(posedge clk) disable iff (!rstN)
    (errIntEn && (crcError || overrun || modeFault)) |-> irq);
endmodule

// File: rtl/spi_err_irq.sv
module spi_err_irq
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nssPin,
  input  logic              nssHwMode,
  input  logic              ssiBit,
  input  logic              ctrlWr,
  input  logic              wrEnable,
  input  logic              wrMaster,
  input  logic              stsRd,
  input  logic              stsWr,
  input  logic              stsWrCrcErr,
  input  logic              datRd,
  input  logic              datWr,
  input  logic              txTaken,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              crcCheck,
  input  logic              crcOk,
  input  logic              teIntEn,
  input  logic              rneIntEn,
  input  logic              errIntEn,
  output logic              periphEn,
  output logic              masterSel,
  output logic              txEmpty,
  output logic              rxNotEmpty,
  output logic              modeFault,
  output logic              overrun,
  output logic              crcError,
  output logic [DATA_W-1:0] rxData,
  output logic              irq
);
  flagStrobes_t strb;

  spi_flag_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .nssPin(nssPin), .nssHwMode(nssHwMode),
    .ssiBit(ssiBit), .masterSel(masterSel), .modfFlag(modeFault),
    .ovrFlag(overrun), .ctrlWr(ctrlWr), .stsRd(stsRd), .stsWr(stsWr),
    .stsWrCrcErr(stsWrCrcErr), .datRd(datRd), .crcCheck(crcCheck),
    .crcOk(crcOk), .strb(strb)
  );

  spi_flag_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlWr(ctrlWr),
    .wrEnable(wrEnable), .wrMaster(wrMaster), .datRd(datRd), .datWr(datWr),
    .txTaken(txTaken), .rxValid(rxValid), .rxWord(rxWord),
    .teIntEn(teIntEn), .rneIntEn(rneIntEn), .errIntEn(errIntEn),
    .periphEn(periphEn), .masterSel(masterSel), .txEmpty(txEmpty),
    .rxNotEmpty(rxNotEmpty), .modeFault(modeFault), .overrun(overrun),
    .crcError(crcError), .rxData(rxData), .irq(irq)
  );
endmodule

// File: tb/tb_spi_err_irq.sv
`timescale 1ns/1ps
module tb_spi_err_irq;
  localparam int DATA_W = 16;
  localparam int NVEC   = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nssPin = 1'b1, nssHwMode = 1'b1, ssiBit = 1'b1;
  logic ctrlWr = 0, wrEnable = 0, wrMaster = 0;
  logic stsRd = 0, stsWr = 0, stsWrCrcErr = 0, datRd = 0, datWr = 0;
  logic txTaken = 0, rxValid = 0, crcCheck = 0, crcOk = 0;
  logic teIntEn = 0, rneIntEn = 0, errIntEn = 0;
  logic [DATA_W-1:0] rxWord = '0;
  logic periphEn, masterSel, txEmpty, rxNotEmpty, modeFault, overrun, crcError, irq;
  logic [DATA_W-1:0] rxData;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  spi_err_irq #(.DATA_W(DATA_W)) dut (.*);

  // stimulus {nss hw ssi | cw wen wms | sr sw wcrc | dr rx cchk | cok tt dw}
  // expect   {en ms te rne modf ovr crc}, then requirement number
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {15'b111_111_000_000_000, 7'b1100000, 4'd2},   // R2 write enable and master
    {15'b111_000_000_000_010, 7'b1110000, 4'd11},  // R11 tx taken
    {15'b111_000_000_000_001, 7'b1100000, 4'd11},  // R11 data write
    {15'b111_000_000_010_000, 7'b1101000, 4'd7},   // R7 first word
    {15'b111_000_000_010_000, 7'b1101010, 4'd8},   // R8 second word dropped
    {15'b111_000_000_100_000, 7'b1100010, 4'd9},   // R9 data read arms
    {15'b111_000_011_000_000, 7'b1100010, 4'd9},   // R9 status write aborts
    {15'b111_000_100_000_000, 7'b1100010, 4'd9},   // R9 lone status read
    {15'b111_000_000_100_000, 7'b1100010, 4'd9},   // R9 re-arm
    {15'b111_000_100_000_000, 7'b1100000, 4'd9},   // R9 cleared
    {15'b111_000_000_001_000, 7'b1100001, 4'd10},  // R10 mismatch
    {15'b111_000_000_001_100, 7'b1100001, 4'd10},  // R10 match leaves flag
    {15'b111_000_010_000_000, 7'b1100000, 4'd10},  // R10 write 0 clears
    {15'b011_000_000_000_000, 7'b0000100, 4'd3},   // R3 pin low
    {15'b111_111_000_000_000, 7'b0000100, 4'd5},   // R5 locked write
    {15'b111_000_100_000_000, 7'b0000100, 4'd6},   // R6 status read arms
    {15'b111_000_000_100_000, 7'b0000100, 4'd6},   // R6 data read aborts
    {15'b111_111_000_000_000, 7'b0000100, 4'd6},   // R6 unarmed write
    {15'b111_000_011_000_000, 7'b0000100, 4'd6},   // R6 status write arms
    {15'b111_111_000_000_000, 7'b0000000, 4'd5},   // R5 clearing write ignored
    {15'b111_111_000_000_000, 7'b1100000, 4'd2},   // R2 unlocked again
    {15'b100_000_000_000_000, 7'b0000100, 4'd4}    // R4 software select low
  };

  task automatic idle();
    {nssPin, nssHwMode, ssiBit} = 3'b111;
    {ctrlWr, wrEnable, wrMaster, stsRd, stsWr, stsWrCrcErr} = '0;
    {datRd, datWr, txTaken, rxValid, crcCheck, crcOk} = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] flags();
    return {periphEn, masterSel, txEmpty, rxNotEmpty, modeFault, overrun, crcError};
  endfunction

  task automatic doReset();
    idle();
    rstN = 1'b0;
    #9;
    rstN = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    check("R1 reset flags", 32'(flags()), 32'h0);
    check("R1 reset data/irq", {15'd0, irq, rxData}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [14:0] s;
      s = VEC[i][25:11];
      {nssPin, nssHwMode, ssiBit, ctrlWr, wrEnable, wrMaster, stsRd, stsWr,
       stsWrCrcErr, datRd, rxValid, crcCheck, crcOk, txTaken, datWr} = s;
      rxWord = 16'hA000 + 16'(i);
      step();
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), 32'(flags()), 32'(VEC[i][10:4]));
    end

    // Receive capture in the same cycle as a data read.
    doReset();
    rxValid = 1; rxWord = 16'h1111; step();
    check("R7 first capture", {15'd0, rxNotEmpty, rxData}, {15'd0, 1'b1, 16'h1111});
    rxValid = 1; datRd = 1; rxWord = 16'h2222; step();
    check("R7 capture with read", {14'd0, overrun, rxNotEmpty, rxData}, {14'd0, 2'b01, 16'h2222});
    rxValid = 1; rxWord = 16'h3333; step();
    check("R8 drop keeps data", {14'd0, overrun, rxNotEmpty, rxData}, {14'd0, 2'b11, 16'h2222});
    datRd = 1; step();
    check("R7 read empties", 32'(rxNotEmpty), 32'h0);

    // CRC set against clear, tx set against data write.
    crcCheck = 1; crcOk = 0; stsWr = 1; stsWrCrcErr = 0; txTaken = 1; datWr = 1; step();
    check("R10 set beats clear", 32'(crcError), 32'h1);
    check("R11 taken beats write", 32'(txEmpty), 32'h1);

    // Interrupt combine: te=1 ovr=1 crc=1 rne=0.
    #1 check("R12 no enables", 32'(irq), 32'h0);
    errIntEn = 1; #1 check("R12 error enable", 32'(irq), 32'h1);
    errIntEn = 0; rneIntEn = 1; #1 check("R12 rne enable, rne low", 32'(irq), 32'h0);
    rneIntEn = 0; teIntEn = 1; #1 check("R12 te enable", 32'(irq), 32'h1);
    datWr = 1; step();
    check("R12 te cleared", 32'(irq), 32'h0);
    teIntEn = 0;

    // Fault in the same cycle as a control write.
    ctrlWr = 1; wrEnable = 1; wrMaster = 1; step();
    nssPin = 0; ctrlWr = 1; wrEnable = 1; wrMaster = 1; step();
    check("R5 fault beats write", {29'd0, periphEn, masterSel, modeFault}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule